// File: doc/BRIEF.md
# Variable-Duty Tone Modulator with Undertone

This block makes an audible tone from a single fast PWM bit. A free-running carrier counter turns the output on while it is below the active level. A slower tone counter changes that active level twice in each tone period. When the tone counter wraps, it loads a nonzero volume level. When the tone counter reaches a programmable compare value, it clears the level to zero. The compare-to-top ratio therefore sets the duty of the audible wave, and the loaded level sets its loudness.

A speaker or an RC filter averages the carrier. A typical setup uses a compare value of about 0.6 of the top value and a secondary level of about 15% of the primary. With the harmonic bit set, successive tone periods alternate between a primary and a secondary level. If the tone counter runs at twice the wanted pitch, the result is the fundamental plus a component at twice its frequency. The carrier period is `CAR_TOP+1` counts, which is 500 by default, so useful levels run from 0 to 499. The host computes all the values and presents them as static inputs.

Top module: `tone_duty_mod`

## Requirements
- R1: While `rst_n` is low, and in the state it leaves, `pwm_out` is 0, both counters are 0 and the alternation flag selects the secondary level.
- R2: `pwm_out` is 1 exactly when the carrier count (0..CAR_TOP, period CAR_TOP+1 clocks) is below the active level, so a level above CAR_TOP keeps the output high.
- R3: The tone counter steps 0..`tone_top` and wraps to 0, giving a period of `tone_top`+1 clocks. On each wrap it loads a volume level. Before the first wrap the active level is 0.
- R4: When `tone_cmp` < `tone_top`, the clock edge at which the tone counter equals `tone_cmp` clears the active level to 0. The level is therefore held while the count is 0..`tone_cmp` and is zero for the rest of the period.
- R5: When `tone_cmp` >= `tone_top`, no clear occurs and the loaded level lasts the whole period. When a wrap and a compare fall on the same edge, the wrap wins.
- R6: With `harm_en` = 0, every wrap loads `level_a`.
- R7: With `harm_en` = 1, odd-numbered wraps (counting from 1 after reset) load `level_b` and even-numbered wraps load `level_a`.
- R8: The alternation flag toggles on every wrap, whatever the value of `harm_en`. Turning harmonics on partway through a run therefore follows the wrap parity counted since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_top | input | TW | Last value of the tone counter |
| tone_cmp | input | TW | Tone count at which the level is cleared |
| level_a | input | CW | Primary volume level |
| level_b | input | CW | Secondary (undertone) level |
| harm_en | input | 1 | Alternate primary and secondary levels on successive wraps |
| pwm_out | output | 1 | Carrier PWM bit |

## Verification
The wrap and the compare clear can land on the same clock edge when `tone_cmp` equals `tone_top`. A compare of 0 puts the clear on the edge right after the wrap. A top of 0 makes every edge a wrap. The bench sweeps every compare value from 0 to `tone_top`+1 for several small tops, so these coincidences all occur. It judges each output cycle against a level worked out from the edge count: the wrap number and the position within the period. A run that switches `harm_en` on partway through checks that wrap parity is kept while harmonics are off.

// File: rtl/tone_duty_mod.sv
module tone_duty_mod #(
  parameter int CAR_TOP = 499,
  parameter int TW      = 16,
  parameter int CW      = $clog2(CAR_TOP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tone_top,
  input  logic [TW-1:0] tone_cmp,
  input  logic [CW-1:0] level_a,
  input  logic [CW-1:0] level_b,
  input  logic          harm_en,
  output logic          pwm_out
);

  logic [CW-1:0] car_cnt;
  logic [CW-1:0] level_q;
  logic [TW-1:0] tcnt;
  logic          pick_b;

  wire car_wrap  = car_cnt >= CW'(CAR_TOP);
  wire tone_wrap = tcnt >= tone_top;
  wire cmp_hit   = (tcnt == tone_cmp) && !tone_wrap;
  wire [CW-1:0] next_level = (harm_en && pick_b) ? level_b : level_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_cnt <= '0;
      tcnt    <= '0;
      level_q <= '0;
      pick_b  <= 1'b1;
    end else begin
      car_cnt <= car_wrap ? '0 : car_cnt + CW'(1);
      if (tone_wrap) begin
        tcnt    <= '0;
        level_q <= next_level;
        pick_b  <= ~pick_b;
      end else begin
        tcnt <= tcnt + TW'(1);
        if (cmp_hit) level_q <= '0;
      end
    end
  end

  assign pwm_out = car_cnt < level_q;

endmodule

module tone_duty_mod_chk #(
  parameter int TW = 16,
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] tone_top,
  input logic [TW-1:0] tone_cmp,
  input logic [CW-1:0] level_a,
  input logic [CW-1:0] level_b,
  input logic          harm_en,
  input logic          pwm_out,
  input logic [TW-1:0] tcnt,
  input logic [CW-1:0] level_q,
  input logic          pick_b
);

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !pwm_out && level_q == '0);

  a_r2_zero_level_off: assert property (@(posedge clk) disable iff (!rst_n)
    level_q == '0 |-> !pwm_out);

  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt >= tone_top |=> tcnt == '0);

  a_r4_cmp_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt == tone_cmp && tone_cmp < tone_top && tcnt < tone_top) |=> level_q == '0);

  a_r5_wrap_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt >= tone_top && tcnt == tone_cmp) |=> level_q == $past(harm_en && pick_b ? level_b : level_a));

  a_r6_primary_only: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt >= tone_top && !harm_en) |=> level_q == $past(level_a));

  a_r7_secondary_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt >= tone_top && harm_en && pick_b) |=> level_q == $past(level_b));

  a_r8_flag_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt >= tone_top |=> pick_b != $past(pick_b));

endmodule

bind tone_duty_mod tone_duty_mod_chk #(.TW(TW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tone_top(tone_top), .tone_cmp(tone_cmp),
  .level_a(level_a), .level_b(level_b), .harm_en(harm_en), .pwm_out(pwm_out),
  .tcnt(tcnt), .level_q(level_q), .pick_b(pick_b)
);

// File: tb/tone_duty_mod_test.sv
`timescale 1ns/1ps
module tone_duty_mod_test;
  localparam int CT = 9;
  localparam int TW = 6;
  localparam int CW = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic [TW-1:0] tone_top = '0;
  logic [TW-1:0] tone_cmp = '0;
  logic [CW-1:0] level_a = '0;
  logic [CW-1:0] level_b = '0;
  logic harm_en = 0;
  logic pwm_out;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  tone_duty_mod #(.CAR_TOP(CT), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .tone_top(tone_top), .tone_cmp(tone_cmp),
    .level_a(level_a), .level_b(level_b), .harm_en(harm_en), .pwm_out(pwm_out)
  );

  function automatic int exp_pwm(int n, int top, int cmp, int a, int b, int h1, int h2, int s);
    int p = top + 1;
    int w = n / p;
    int c = n % p;
    int lvl = 0;
    int h;
    if (w > 0) begin
      h = (w * p > s) ? h2 : h1;
      lvl = (h != 0 && (w % 2) == 1) ? b : a;
      if (cmp < top && c > cmp) lvl = 0;
    end
    return ((n % (CT + 1)) < lvl) ? 1 : 0;
  endfunction

  function automatic string tag_of(int n, int top, int cmp, int h, string force_tag);
    int p = top + 1;
    if (n == 0) return "R1";
    if (force_tag != "") return force_tag;
    if (n / p == 0) return "R3";
    if (cmp >= top) return "R5";
    if ((n % p) > cmp) return "R4";
    return (h != 0) ? "R7" : "R6";
  endfunction

  task automatic run(int top, int cmp, int a, int b, int h1, int h2, int s, string ft);
    int len = 4 * (top + 1) + 3;
    rst_n = 0;
    tone_top = TW'(top);
    tone_cmp = TW'(cmp);
    level_a = CW'(a);
    level_b = CW'(b);
    harm_en = h1[0];
    @(negedge clk);
    total++;
    if (pwm_out !== 1'b0) begin
      bad++;
      $display("FAIL R1 in reset: pwm_out=%b expected 0", pwm_out);
    end
    rst_n = 1;
    for (int n = 0; n <= len; n++) begin
      int e;
      string t;
      if (n > 0) @(negedge clk);
      e = exp_pwm(n, top, cmp, a, b, h1, h2, s);
      t = tag_of(n, top, cmp, (n > s) ? h2 : h1, ft);
      total++;
      if (pwm_out !== e[0]) begin
        bad++;
        $display("FAIL %s top=%0d cmp=%0d n=%0d: pwm_out=%b expected %0d", t, top, cmp, n, pwm_out, e);
      end
      if (n == s) harm_en = h2[0];
    end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog expired: running expected finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int tops[4] = '{0, 1, 3, 6};
    repeat (3) @(negedge clk);
    // R3 R4 R5 R6 R7: sweep compare across each small top, harmonics off and on
    foreach (tops[i]) begin
      for (int c = 0; c <= tops[i] + 1; c++) begin
        run(tops[i], c, 7, 2, 0, 0, 1000, "");
        run(tops[i], c, 7, 2, 1, 1, 1000, "");
      end
    end
    // R2: level above CAR_TOP saturates high; zero level stays low
    run(3, 9, 12, 12, 0, 0, 1000, "R2");
    run(3, 9, 0, 0, 1, 1, 1000, "R2");
    run(5, 9, 9, 10, 1, 1, 1000, "R2");
    // R8: harmonics switched on after first wrap; parity counted from reset
    run(3, 9, 8, 3, 0, 1, 5, "R8");
    run(2, 1, 8, 3, 0, 1, 4, "R8");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule